// File: doc/BRIEF.md
# Atomic Split Duty Register Access Port

This block lets a processor with an 8-bit data bus read and write a 12-bit PWM duty value without ever exposing a torn value. The duty value is stored as an 8-bit main register (bits 11:4) and a 4-bit low extension (bits 3:0). A single hidden 4-bit holding buffer sits between the bus and the low extension. It is used in both directions. On writes, the low part is staged in the buffer and only reaches the live register when the main register is written. On reads, reading the main register captures the live low part into the buffer, so a later low-part read returns the value that belonged with the main byte already read.

Software writes the low part first, then the main part. It reads the main part first, then the low part. The live 12-bit value presented to the PWM core therefore changes in one step, on the main-register write.

Top module: `duty_split_access`

## Requirements
- R1: A synchronous active-high reset clears the main register, the low extension and the holding buffer to zero. It also clears `rd_data` to zero, so `duty` reads 0 after reset and a following low-part read returns 0.
- R2: A write with `sel_low`=1 stores `wr_data[3:0]` in the holding buffer only. `duty` stays unchanged.
- R3: A write with `sel_low`=0 loads `wr_data` into `duty[11:4]`. At the same clock edge it loads the holding buffer into `duty[3:0]`. Both take effect one cycle after the write.
- R4: A read with `sel_low`=0 returns the main register (`duty[11:4]`) on `rd_data` one cycle later. At the same edge it copies the live low extension (`duty[3:0]`) into the holding buffer.
- R5: A read with `sel_low`=1 returns the holding buffer, not the live low extension, on `rd_data[3:0]` one cycle later, with `rd_data[7:4]` = 0.
- R6: `duty` changes only at the clock edge of a main-register write (or reset).
- R7: A low-part write ignores `wr_data[7:4]`.
- R8: When `wr_en` and `rd_en` are both high, the cycle is a write only: `rd_data` holds and the holding buffer is not captured by the read.
- R9: `rd_data` holds its previous value in every cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_low | input | 1 | Address select: 0 = main register, 1 = low extension |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (ignored when `wr_en` is high) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| duty | output | 12 | Live duty value: main register in 11:4, low extension in 3:0 |

## Verification
Every result is due exactly one clock edge after the strobe that causes it. Writes reach `duty` at that edge. A read's data appears on `rd_data` at that edge. A buffer load or capture becomes visible through the next low-part read. The bench drives inputs on the falling edge and updates its own model at the rising edge from the values held before that edge. It compares `duty` and `rd_data` at the following falling edge, so each check lands one cycle after its stimulus. Effects on the hidden buffer are observed by a later low-part read or main-register write.

// File: rtl/duty_split_pkg.sv
package duty_split_pkg;
  typedef enum logic {
    SEL_MAIN = 1'b0,
    SEL_LOW  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic wr_main;
    logic wr_low;
    logic rd_main;
    logic rd_low;
  } access_t;
endpackage

// File: rtl/duty_split_access.sv
module dsa_decode
  import duty_split_pkg::*;
(
  input  logic    sel_low,
  input  logic    wr_en,
  input  logic    rd_en,
  output access_t acc
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_low);

  always_comb begin
    acc.wr_main = wr_en && (sel == SEL_MAIN);
    acc.wr_low  = wr_en && (sel == SEL_LOW);
    acc.rd_main = rd_en && !wr_en && (sel == SEL_MAIN);
    acc.rd_low  = rd_en && !wr_en && (sel == SEL_LOW);
  end
endmodule

module dsa_hold_buf
  import duty_split_pkg::*;
#(
  parameter int EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  access_t          acc,
  input  logic [EXT_W-1:0] wr_low_bits,
  input  logic [EXT_W-1:0] live_low,
  output logic [EXT_W-1:0] buf_q
);
  always_ff @(posedge clk) begin
    if (rst)              buf_q <= '0;
    else if (acc.wr_low)  buf_q <= wr_low_bits;
    else if (acc.rd_main) buf_q <= live_low;
  end
endmodule

module dsa_live_regs
  import duty_split_pkg::*;
#(
  parameter int MAIN_W = 8,
  parameter int EXT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  access_t           acc,
  input  logic [MAIN_W-1:0] wr_main_bits,
  input  logic [EXT_W-1:0]  buf_q,
  output logic [MAIN_W-1:0] main_q,
  output logic [EXT_W-1:0]  low_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
      low_q  <= '0;
    end else if (acc.wr_main) begin
      main_q <= wr_main_bits;
      low_q  <= buf_q;
    end
  end
endmodule

module dsa_read_port
  import duty_split_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EXT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  access_t           acc,
  input  logic [DATA_W-1:0] main_q,
  input  logic [EXT_W-1:0]  buf_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - EXT_W;

  always_ff @(posedge clk) begin
    if (rst)              rd_data <= '0;
    else if (acc.rd_main) rd_data <= main_q;
    else if (acc.rd_low)  rd_data <= {{PAD_W{1'b0}}, buf_q};
  end
endmodule

module duty_split_access
  import duty_split_pkg::*;
#(
  parameter int MAIN_W = 8,
  parameter int EXT_W  = 4,
  parameter int DATA_W = MAIN_W,
  parameter int DUTY_W = MAIN_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_low,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DUTY_W-1:0] duty
);
  access_t           acc;
  logic [EXT_W-1:0]  buf_q;
  logic [MAIN_W-1:0] main_q;
  logic [EXT_W-1:0]  low_q;

  dsa_decode u_decode (
    .sel_low (sel_low),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .acc     (acc)
  );

  dsa_hold_buf #(.EXT_W(EXT_W)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .acc         (acc),
    .wr_low_bits (wr_data[EXT_W-1:0]),
    .live_low    (low_q),
    .buf_q       (buf_q)
  );

  dsa_live_regs #(.MAIN_W(MAIN_W), .EXT_W(EXT_W)) u_live (
    .clk          (clk),
    .rst          (rst),
    .acc          (acc),
    .wr_main_bits (wr_data[MAIN_W-1:0]),
    .buf_q        (buf_q),
    .main_q       (main_q),
    .low_q        (low_q)
  );

  dsa_read_port #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_rdport (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .main_q  (main_q),
    .buf_q   (buf_q),
    .rd_data (rd_data)
  );

  assign duty = {main_q, low_q};
endmodule

// File: rtl/duty_split_access_chk.sv
module duty_split_access_chk #(
  parameter int MAIN_W = 8,
  parameter int EXT_W  = 4,
  parameter int DATA_W = MAIN_W,
  parameter int DUTY_W = MAIN_W + EXT_W
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_low,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [DUTY_W-1:0] duty
);
  logic rst_q;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (duty == '0 && rd_data == '0)
        else $error("R1 outputs not cleared after reset");
    end
    rst_q <= rst;
  end

  assert_main_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel_low) |=> duty[DUTY_W-1:EXT_W] == $past(wr_data[MAIN_W-1:0]));

  assert_main_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !sel_low) |=> rd_data == $past(duty[DUTY_W-1:EXT_W]));

  assert_low_read_pad_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && sel_low) |=> rd_data[DATA_W-1:EXT_W] == '0);

  assert_duty_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !sel_low) |=> $stable(duty));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> $stable(rd_data));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind duty_split_access duty_split_access_chk #(
  .MAIN_W(MAIN_W), .EXT_W(EXT_W), .DATA_W(DATA_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk(clk), .rst(rst), .sel_low(sel_low), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .duty(duty)
);

// File: tb/duty_split_access_bench.sv
`timescale 1ns/1ps
module duty_split_access_bench;
  localparam int MW = 8;
  localparam int EW = 4;
  localparam int DW = MW + EW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_low = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [MW-1:0] wr_data = '0;
  logic [MW-1:0] rd_data;
  logic [DW-1:0] duty;

  int tests = 0;
  int fails = 0;

  logic [MW-1:0] m_main = '0;
  logic [EW-1:0] m_low = '0;
  logic [EW-1:0] m_buf = '0;
  logic [MW-1:0] m_rd = '0;

  always #5 clk = ~clk;

  duty_split_access u_duty_split_access (
    .clk(clk), .rst(rst), .sel_low(sel_low), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .duty(duty)
  );

  function automatic logic [DW-1:0] exp_duty();
    return {m_main, m_low};
  endfunction

  function automatic logic [MW-1:0] exp_low_read();
    return {{(MW-EW){1'b0}}, m_buf};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, model at rising edge, check at next falling edge
  task automatic op(input logic s, input logic w, input logic r, input logic [MW-1:0] d,
                    input string req);
    sel_low = s; wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    if (w) begin
      if (s) m_buf = d[EW-1:0];
      else begin m_main = d; m_low = m_buf; end
    end else if (r) begin
      if (s) m_rd = exp_low_read();
      else begin m_rd = m_main; m_buf = m_low; end
    end
    @(negedge clk);
    sel_low = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    check({req, " duty"}, 32'(duty), 32'(exp_duty()));
    check({req, " rd_data"}, 32'(rd_data), 32'(m_rd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 duty", 32'(duty), 32'h0);
    check("R1 rd_data", 32'(rd_data), 32'h0);
    op(1'b1, 1'b0, 1'b1, 8'h00, "R1 low read after reset");

    // R2 / R7: low write with upper bits set, duty unchanged, buffer gets low nibble
    op(1'b1, 1'b1, 1'b0, 8'hF5, "R2 low write");
    op(1'b1, 1'b0, 1'b1, 8'h00, "R7 upper bits ignored");
    check("R7 low read value", 32'(rd_data), 32'h05);

    // R3: main write commits buffer
    op(1'b0, 1'b1, 1'b0, 8'hA3, "R3 main write");
    check("R3 duty value", 32'(duty), 32'hA35);

    // R5: low read returns buffer, not live low
    op(1'b1, 1'b1, 1'b0, 8'h0C, "R2 restage");
    op(1'b1, 1'b0, 1'b1, 8'h00, "R5 low read buffer");
    check("R5 buffer not live", 32'(rd_data), 32'h0C);

    // R4: main read snapshots live low into buffer
    op(1'b0, 1'b0, 1'b1, 8'h00, "R4 main read");
    check("R4 main value", 32'(rd_data), 32'hA3);
    op(1'b1, 1'b0, 1'b1, 8'h00, "R4 snapshot via low read");
    check("R4 snapshot value", 32'(rd_data), 32'h05);

    // R8: simultaneous strobes act as write only
    op(1'b1, 1'b1, 1'b1, 8'h09, "R8 low write+read");
    op(1'b0, 1'b1, 1'b1, 8'h71, "R8 main write+read");
    check("R8 duty value", 32'(duty), 32'h719);
    check("R8 rd_data held", 32'(rd_data), 32'h05);

    // R9: idle cycles hold rd_data; R6 duty held
    op(1'b0, 1'b0, 1'b0, 8'hFF, "R9 idle");
    op(1'b1, 1'b0, 1'b0, 8'hFF, "R6 idle");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic s, w, r;
      logic [MW-1:0] d;
      s = 1'($urandom);
      w = ($urandom % 3) == 0;
      r = ($urandom % 2) == 0;
      d = 8'($urandom);
      op(s, w, r, d, "R6 random");
    end

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_main = '0; m_low = '0; m_buf = '0; m_rd = '0;
    check("R1 duty after reset", 32'(duty), 32'h0);
    op(1'b0, 1'b1, 1'b0, 8'h44, "R1 buffer cleared");
    check("R1 buffer cleared value", 32'(duty), 32'h440);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule